// File: doc/BRIEF.md
# USB Full-Speed Frame Timer with Done-Queue Delay

This block keeps frame time for a full-speed USB host controller. Each bit-time tick (12 MHz) advances an elapsed-time counter inside the current 1 ms frame. When the frame interval has been used up, the block starts a new frame. At that point it advances a frame number that wraps at its width, copies the interval toggle into a remaining-toggle bit, and pulses a start-of-frame strobe. It pulses a frame-overflow strobe whenever the top bit of the frame number changes. The low five bits of the frame number select which of 32 periodic list heads the scheduler walks in that frame.

The block also holds the frame-interval register. That register has a 14-bit interval, a 15-bit largest-data-packet field and a toggle bit. A companion frame-remaining word reports the toggle and the bit times left in the frame.

The done-queue delay counter sits alongside the timer. Each retired transfer reports a 3-bit delay code, and the counter keeps the smallest code reported. The counter counts down one step per frame. When it reaches zero at a frame boundary, and no writeback is already pending, the block fires the done-head writeback strobe and returns the counter to its idle value.

Frames run only while the controller functional state is operational. Entering that state starts a fresh frame at once.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the interval word reads 0x27782EDF (interval 0x2EDF, packet field 0x2778, toggle 0), the frame number is 0, the remaining-toggle is 0, the delay counter is 7 and all three strobes are low.
- R2: A write to the interval word loads the interval from bits 13:0, the packet field from bits 30:16 and the toggle from bit 31. Written bits 15:14 are dropped and read as 0.
- R3: The functional state is 2 bits: 00 reset, 01 resume, 10 operational, 11 suspend. In every state other than 10 the frame number and elapsed time do not advance, whatever the tick input does.
- R4: In the cycle after the state input first shows 10, the start-of-frame strobe is high and the new frame begins with zero bit times elapsed. The frame number does not change.
- R5: While operational, a tick that arrives with elapsed time greater than or equal to the interval ends the frame. A frame with an unchanged interval therefore lasts interval+1 ticks, and an interval lowered below the elapsed time ends the frame at the next tick.
- R6: While operational, the remaining word carries the remaining-toggle at bit 31 and the interval minus the elapsed bit times at bits 13:0 (0 if the elapsed time exceeds the interval). All other bits are 0.
- R7: Outside the operational state, the remaining word carries only the remaining-toggle at bit 31, and all other bits are 0.
- R8: At a frame end the remaining-toggle takes the interval toggle and the frame number increments modulo 2^FN_W. In the next cycle the start-of-frame strobe is high.
- R9: The periodic list index equals bits 4:0 of the frame number.
- R10: The frame-overflow strobe is high, in the cycle after a frame end, exactly when that frame end changed the top bit of the frame number.
- R11: A retire strobe whose delay code is below the counter lowers the counter to that code. A code equal to or above the counter leaves it unchanged.
- R12: At a frame end, if the counter is 0 and the writeback-pending input is low, the writeback strobe is high in the next cycle and the counter returns to 7. If the pending input is high, the counter stays 0 and no strobe fires.
- R13: At a frame end, a counter between 1 and 6 decrements by one, and a counter of 7 stays 7.
- R14: A retire in the same cycle as a frame end is folded into the counter first. The frame-end rule of R12 or R13 then applies to the lowered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One full-speed bit time has elapsed |
| hc_state | input | 2 | Controller functional state (00 reset, 01 resume, 10 operational, 11 suspend) |
| fmi_wr | input | 1 | Write strobe for the frame-interval word |
| fmi_wdata | input | 32 | Frame-interval write data |
| retire_vld | input | 1 | A transfer retired this cycle |
| retire_dly | input | DLY_W | Delay code carried by the retired transfer |
| wd_pending | input | 1 | Writeback status already set and not yet cleared |
| fmi_rdata | output | 32 | Frame-interval word readback |
| frem_rdata | output | 32 | Frame-remaining word readback |
| frame_num | output | FN_W | Current frame number |
| list_idx | output | 5 | Periodic list index for the current frame |
| sof_evt | output | 1 | Start-of-frame strobe |
| fno_evt | output | 1 | Frame-number overflow strobe |
| wb_evt | output | 1 | Done-head writeback strobe |
| dly_count | output | DLY_W | Done-queue delay counter value |

## Verification
The bench builds the block with an 8-bit frame number and keeps the 14-bit interval and 3-bit delay code. It then writes intervals of 0 to 4, so each frame lasts only a few cycles. With these settings, a run of a few thousand cycles passes through hundreds of frames. It wraps the frame number and crosses the overflow bit in both directions. It lowers the interval below the elapsed time. Retire codes, pending flags and frame ends coincide in many combinations, so every counter value meets every frame-end rule. A reference model in the bench predicts every output on every cycle.

// File: rtl/usbft_pkg.sv
package usbft_pkg;

  // Controller functional state; the encoding is decoded by this block.
  typedef enum logic [1:0] {
    HCS_RESET   = 2'b00,
    HCS_RESUME  = 2'b01,
    HCS_OPER    = 2'b10,
    HCS_SUSPEND = 2'b11
  } hc_state_e;

  localparam int REG_W      = 32;
  localparam int FSMPS_W    = 15;  // packet field occupies bits 30:16
  localparam int FSMPS_LSB  = 16;
  localparam int TOGGLE_BIT = 31;
  localparam int LIST_IDX_W = 5;   // 32 periodic list heads

endpackage

// File: rtl/usbft_interval_reg.sv
module usbft_interval_reg
  import usbft_pkg::*;
#(
  parameter int                  FI_W        = 14,
  parameter logic [FI_W-1:0]     FI_RESET    = 14'h2EDF,
  parameter logic [FSMPS_W-1:0]  FSMPS_RESET = 15'h2778
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [FI_W-1:0]     fi,
  output logic [FSMPS_W-1:0]  fsmps,
  output logic                fit,
  output logic [REG_W-1:0]    rd_word
);

  localparam int GAP_W = FSMPS_LSB - FI_W;

  // Field extraction kept in functions so the layout lives in one place.
  function automatic logic [FI_W-1:0] field_fi(input logic [REG_W-1:0] w);
    return w[FI_W-1:0];
  endfunction

  function automatic logic [FSMPS_W-1:0] field_fsmps(input logic [REG_W-1:0] w);
    return w[FSMPS_LSB +: FSMPS_W];
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input logic t,
                                                 input logic [FSMPS_W-1:0] p,
                                                 input logic [FI_W-1:0] f);
    return {t, p, {GAP_W{1'b0}}, f};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi    <= FI_RESET;
      fsmps <= FSMPS_RESET;
      fit   <= 1'b0;
    end else if (wr_en) begin
      fi    <= field_fi(wr_data);
      fsmps <= field_fsmps(wr_data);
      fit   <= wr_data[TOGGLE_BIT];
    end
  end

  assign rd_word = pack_word(fit, fsmps, fi);

endmodule

// File: rtl/usbft_frame_seq.sv
module usbft_frame_seq #(
  parameter int FI_W = 14,
  parameter int FN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             oper,
  input  logic [FI_W-1:0]  fi,
  input  logic             fit,
  output logic [FI_W-1:0]  elapsed,
  output logic [FN_W-1:0]  frame_num,
  output logic             frt,
  output logic             bus_start,
  output logic             frame_boundary,
  output logic             sof_q,
  output logic             fno_q
);

  logic            oper_q;
  logic            running;
  logic [FN_W-1:0] fn_next;
  logic            msb_flip;

  function automatic logic [FN_W-1:0] fn_advance(input logic [FN_W-1:0] n);
    return n + {{(FN_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic top_bit_changed(input logic [FN_W-1:0] a,
                                           input logic [FN_W-1:0] b);
    return a[FN_W-1] ^ b[FN_W-1];
  endfunction

  // Frame ends once the interval has been used up; >= covers an interval
  // lowered below the time already spent in the frame.
  function automatic logic interval_spent(input logic [FI_W-1:0] el,
                                          input logic [FI_W-1:0] lim);
    return el >= lim;
  endfunction

  assign bus_start      = oper & ~oper_q;
  assign running        = oper & oper_q;
  assign frame_boundary = running & bit_tick & interval_spent(elapsed, fi);
  assign fn_next        = fn_advance(frame_num);
  assign msb_flip       = top_bit_changed(frame_num, fn_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oper_q    <= 1'b0;
      elapsed   <= '0;
      frame_num <= '0;
      frt       <= 1'b0;
      sof_q     <= 1'b0;
      fno_q     <= 1'b0;
    end else begin
      oper_q <= oper;
      sof_q  <= bus_start | frame_boundary;
      fno_q  <= frame_boundary & msb_flip;
      if (!running || frame_boundary) begin
        elapsed <= '0;
      end else if (bit_tick) begin
        elapsed <= elapsed + {{(FI_W-1){1'b0}}, 1'b1};
      end
      if (frame_boundary) begin
        frame_num <= fn_next;
        frt       <= fit;
      end
    end
  end

endmodule

// File: rtl/usbft_done_delay.sv
module usbft_done_delay #(
  parameter int DLY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_boundary,
  input  logic              retire_vld,
  input  logic [DLY_W-1:0]  retire_dly,
  input  logic              wd_pending,
  output logic [DLY_W-1:0]  count,
  output logic              wb_fire,
  output logic              wb_q
);

  localparam logic [DLY_W-1:0] DLY_IDLE = '1;
  localparam logic [DLY_W-1:0] DLY_ZERO = '0;

  logic [DLY_W-1:0] lowered;
  logic [DLY_W-1:0] count_nxt;

  // Smallest delay requested so far wins.
  function automatic logic [DLY_W-1:0] take_min(input logic [DLY_W-1:0] cur,
                                                 input logic v,
                                                 input logic [DLY_W-1:0] code);
    return (v && code < cur) ? code : cur;
  endfunction

  // Per-frame step: idle value and zero hold, everything else counts down.
  function automatic logic [DLY_W-1:0] frame_step(input logic [DLY_W-1:0] c);
    return (c != DLY_IDLE && c != DLY_ZERO) ? c - {{(DLY_W-1){1'b0}}, 1'b1} : c;
  endfunction

  assign lowered = take_min(count, retire_vld, retire_dly);
  assign wb_fire = frame_boundary & (lowered == DLY_ZERO) & ~wd_pending;

  always_comb begin
    if (wb_fire)             count_nxt = DLY_IDLE;
    else if (frame_boundary) count_nxt = frame_step(lowered);
    else                     count_nxt = lowered;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= DLY_IDLE;
      wb_q  <= 1'b0;
    end else begin
      count <= count_nxt;
      wb_q  <= wb_fire;
    end
  end

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usbft_pkg::*;
#(
  parameter int                  FI_W        = 14,
  parameter int                  FN_W        = 16,
  parameter int                  DLY_W       = 3,
  parameter logic [FI_W-1:0]     FI_RESET    = 14'h2EDF,
  parameter logic [FSMPS_W-1:0]  FSMPS_RESET = 15'h2778
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_tick,
  input  logic [1:0]             hc_state,
  input  logic                   fmi_wr,
  input  logic [REG_W-1:0]       fmi_wdata,
  input  logic                   retire_vld,
  input  logic [DLY_W-1:0]       retire_dly,
  input  logic                   wd_pending,
  output logic [REG_W-1:0]       fmi_rdata,
  output logic [REG_W-1:0]       frem_rdata,
  output logic [FN_W-1:0]        frame_num,
  output logic [LIST_IDX_W-1:0]  list_idx,
  output logic                   sof_evt,
  output logic                   fno_evt,
  output logic                   wb_evt,
  output logic [DLY_W-1:0]       dly_count
);

  localparam int REM_PAD_W = REG_W - 1 - FI_W;

  // Named internal events, visible to the bound checker.
  logic              oper;
  logic              bus_start;
  logic              frame_boundary;
  logic              wb_fire;
  logic [FI_W-1:0]   fi;
  logic [FSMPS_W-1:0] fsmps;
  logic              fit;
  logic              frt;
  logic [FI_W-1:0]   elapsed;

  function automatic logic [FI_W-1:0] bits_left(input logic [FI_W-1:0] lim,
                                                input logic [FI_W-1:0] el);
    return (el > lim) ? '0 : lim - el;
  endfunction

  function automatic logic [REG_W-1:0] pack_remaining(input logic on,
                                                      input logic tog,
                                                      input logic [FI_W-1:0] left);
    return on ? {tog, {REM_PAD_W{1'b0}}, left} : {tog, {(REG_W-1){1'b0}}};
  endfunction

  assign oper = (hc_state == HCS_OPER);

  usbft_interval_reg #(
    .FI_W        (FI_W),
    .FI_RESET    (FI_RESET),
    .FSMPS_RESET (FSMPS_RESET)
  ) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fmi_wr),
    .wr_data (fmi_wdata),
    .fi      (fi),
    .fsmps   (fsmps),
    .fit     (fit),
    .rd_word (fmi_rdata)
  );

  usbft_frame_seq #(
    .FI_W (FI_W),
    .FN_W (FN_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_tick       (bit_tick),
    .oper           (oper),
    .fi             (fi),
    .fit            (fit),
    .elapsed        (elapsed),
    .frame_num      (frame_num),
    .frt            (frt),
    .bus_start      (bus_start),
    .frame_boundary (frame_boundary),
    .sof_q          (sof_evt),
    .fno_q          (fno_evt)
  );

  usbft_done_delay #(
    .DLY_W (DLY_W)
  ) u_delay (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_boundary (frame_boundary),
    .retire_vld     (retire_vld),
    .retire_dly     (retire_dly),
    .wd_pending     (wd_pending),
    .count          (dly_count),
    .wb_fire        (wb_fire),
    .wb_q           (wb_evt)
  );

  assign list_idx   = frame_num[LIST_IDX_W-1:0];
  assign frem_rdata = pack_remaining(oper, frt, bits_left(fi, elapsed));

endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
  parameter int FN_W  = 16,
  parameter int DLY_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        hc_state,
  input logic              wd_pending,
  input logic              bus_start,
  input logic              frame_boundary,
  input logic [FN_W-1:0]   frame_num,
  input logic              sof_evt,
  input logic              fno_evt,
  input logic              wb_evt,
  input logic [DLY_W-1:0]  dly_count,
  input logic [31:0]       frem_rdata
);

  localparam logic [DLY_W-1:0] IDLE = '1;

  AST_SOF_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_boundary |=> sof_evt); // R8

  AST_SOF_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> sof_evt); // R4

  AST_FN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_boundary |=> frame_num == FN_W'($past(frame_num) + 1'b1)); // R8

  AST_FN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_boundary |=> $stable(frame_num)); // R3

  AST_NO_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hc_state != 2'b10 |-> !frame_boundary); // R3

  AST_REM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hc_state != 2'b10 |-> frem_rdata[30:0] == 31'd0); // R7

  AST_WB_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt |-> dly_count == IDLE); // R12

  AST_WB_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_boundary && wd_pending |=> !wb_evt); // R12

  AST_FNO_WITH_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    fno_evt |-> sof_evt); // R10

endmodule

bind usb_frame_timer usb_frame_timer_chk #(
  .FN_W  (FN_W),
  .DLY_W (DLY_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hc_state       (hc_state),
  .wd_pending     (wd_pending),
  .bus_start      (bus_start),
  .frame_boundary (frame_boundary),
  .frame_num      (frame_num),
  .sof_evt        (sof_evt),
  .fno_evt        (fno_evt),
  .wb_evt         (wb_evt),
  .dly_count      (dly_count),
  .frem_rdata     (frem_rdata)
);

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FI_W  = 14;
  localparam int FN_W  = 8;
  localparam int DLY_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bit_tick = 1'b0;
  logic [1:0]        hc_state = 2'b00;
  logic              fmi_wr = 1'b0;
  logic [31:0]       fmi_wdata = '0;
  logic              retire_vld = 1'b0;
  logic [DLY_W-1:0]  retire_dly = '0;
  logic              wd_pending = 1'b0;
  logic [31:0]       fmi_rdata;
  logic [31:0]       frem_rdata;
  logic [FN_W-1:0]   frame_num;
  logic [4:0]        list_idx;
  logic              sof_evt;
  logic              fno_evt;
  logic              wb_evt;
  logic [DLY_W-1:0]  dly_count;

  usb_frame_timer #(.FI_W(FI_W), .FN_W(FN_W), .DLY_W(DLY_W)) u_usb_frame_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .hc_state(hc_state),
    .fmi_wr(fmi_wr), .fmi_wdata(fmi_wdata), .retire_vld(retire_vld),
    .retire_dly(retire_dly), .wd_pending(wd_pending), .fmi_rdata(fmi_rdata),
    .frem_rdata(frem_rdata), .frame_num(frame_num), .list_idx(list_idx),
    .sof_evt(sof_evt), .fno_evt(fno_evt), .wb_evt(wb_evt), .dly_count(dly_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference state
  longint m_el, m_fi, m_fsmps, m_fit, m_frt, m_fn, m_cnt, m_opq;
  longint e_sof, e_fno, e_wb;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string fn_req, input string sof_req,
                             input string cnt_req, input bit op);
    longint rem;
    rem = (m_fi >= m_el) ? (m_fi - m_el) : 0;
    chk(fn_req, "frame_num", frame_num, m_fn);
    chk("R9", "list_idx", list_idx, m_fn % 32);
    chk(sof_req, "sof_evt", sof_evt, e_sof);
    chk("R10", "fno_evt", fno_evt, e_fno);
    chk("R12", "wb_evt", wb_evt, e_wb);
    chk(cnt_req, "dly_count", dly_count, m_cnt);
    chk("R2", "fmi_rdata", fmi_rdata, (m_fit << 31) | (m_fsmps << 16) | m_fi);
    if (op) chk("R6", "frem_rdata", frem_rdata, (m_frt << 31) | rem);
    else    chk("R7", "frem_rdata", frem_rdata, m_frt << 31);
  endtask

  task automatic step(input logic [1:0] st, input bit tk, input bit wr,
                      input logic [31:0] wd, input bit rv,
                      input logic [DLY_W-1:0] rd, input bit pend);
    bit op, start, bnd;
    longint eff, nfn;
    string fn_req, sof_req, cnt_req;
    hc_state = st; bit_tick = tk; fmi_wr = wr; fmi_wdata = wd;
    retire_vld = rv; retire_dly = rd; wd_pending = pend;
    op    = (st == 2'b10);
    start = op && (m_opq == 0);
    bnd   = op && (m_opq != 0) && tk && (m_el >= m_fi);
    eff   = (rv && rd < m_cnt) ? rd : m_cnt;
    e_wb  = (bnd && eff == 0 && !pend) ? 1 : 0;
    cnt_req = (rv && bnd) ? "R14" : bnd ? ((eff == 0) ? "R12" : "R13") : "R11";
    if (e_wb != 0)                  m_cnt = 7;
    else if (bnd && eff != 7 && eff != 0) m_cnt = eff - 1;
    else                            m_cnt = eff;
    nfn   = bnd ? ((m_fn + 1) % 256) : m_fn;
    e_fno = (bnd && ((nfn >> 7) & 1) != ((m_fn >> 7) & 1)) ? 1 : 0;
    e_sof = (start || bnd) ? 1 : 0;
    fn_req  = op ? "R8" : "R3";
    sof_req = start ? "R4" : "R5";
    if (bnd) m_frt = m_fit;
    m_fn = nfn;
    if (!op || start || bnd) m_el = 0;
    else if (tk)             m_el = m_el + 1;
    if (wr) begin
      m_fi    = wd & 32'h3FFF;
      m_fsmps = (wd >> 16) & 32'h7FFF;
      m_fit   = (wd >> 31) & 1;
    end
    m_opq = op ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    compare_all(fn_req, sof_req, cnt_req, op);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_el = 0; m_fi = 14'h2EDF; m_fsmps = 15'h2778; m_fit = 0; m_frt = 0;
    m_fn = 0; m_cnt = 7; m_opq = 0; e_sof = 0; e_fno = 0; e_wb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1", "fmi_rdata", fmi_rdata, 32'h27782EDF);
    chk("R1", "frame_num", frame_num, 0);
    chk("R1", "frem_rdata", frem_rdata, 0);
    chk("R1", "dly_count", dly_count, 7);
    chk("R1", "events", {sof_evt, fno_evt, wb_evt}, 0);

    // R3: non-operational states with ticks; retires still lower the counter (R11)
    for (int i = 0; i < 24; i++)
      step((i % 3 == 0) ? 2'b00 : (i % 3 == 1) ? 2'b01 : 2'b11, 1'b1, 1'b0, '0,
           (i == 5 || i == 9), (i == 5) ? 3'd5 : 3'd6, 1'b0);

    // R2: interval write with bits 15:14 set
    step(2'b00, 1'b0, 1'b1, 32'h8005_C003, 1'b0, '0, 1'b0);

    // Operational sweep: R4..R14
    for (int i = 0; i < 2600; i++) begin
      bit wr;
      logic [31:0] wd;
      wr = (i % 97 == 50);
      wd = {((i / 97) % 2 == 1), 15'(i / 97), 2'b11, 14'((i / 97) % 5)};
      step(2'b10, (i % 3 != 2), wr, wd, (i % 5 == 0 || i % 7 == 3),
           3'((i * 7 + i / 13) % 8), (i % 11 == 4));
    end

    // R7: leave operational, then re-enter (R4)
    for (int i = 0; i < 10; i++)
      step(2'b11, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
    for (int i = 0; i < 40; i++)
      step(2'b10, 1'b1, 1'b0, '0, (i == 2), 3'd1, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule